// File: doc/BRIEF.md
# Power-On Reset Delay Sequencer

This block produces the internal reset of a small microcontroller. It watches two release conditions: a power-good level, which goes high once the supply has climbed past its power-on threshold, and an active-low external reset pin whose level has already been detected. While either condition holds the part in reset, the internal reset stays asserted. Once both are released, a counter runs on a free-running slow oscillator that is separate from the system clock. The counter keeps the reset asserted until a chosen number of oscillator cycles have gone by.

A static option input selects the delay. When it is high, the timeout is short, which suits fast-starting clock sources. When it is low, the timeout is long. The counter starts from the later of the two releases, so a slow supply ramp or an external pin held low simply pushes the start of the count back. The block gives two outputs. One is the reset in the oscillator domain. The other is a copy that is asserted asynchronously and released in step with the system clock.

Top module: `por_delay_seq`

## Requirements
- R1: While `pwr_good` is low or `ext_rst_n` is low, both `rst_int` and `rst_sys` are high (1 = reset asserted), including the state right after power is applied.
- R2: With `fast_start` = 1, `rst_int` falls on the (SHORT_CYCLES + 2)th rising edge of `osc_clk` after both release conditions become true. The two extra edges are the input synchronizer.
- R3: With `fast_start` = 0, `rst_int` falls on the (LONG_CYCLES + 2)th rising edge of `osc_clk` after both release conditions become true.
- R4: The timeout is measured from the later of the two releases. While only one of the two conditions is released, no time is counted and `rst_int` stays high.
- R5: If either release condition drops, during the count or after it, `rst_int` and `rst_sys` go high at once without waiting for any clock edge. The next release starts a full count from zero.
- R6: `fast_start` is sampled only while the block is held in reset. A change on it after both releases have passed the synchronizer does not alter the timeout in progress.
- R7: Once the timeout completes, the counter stops and `rst_int` stays low indefinitely without wrapping, until the next release condition drops.
- R8: `rst_sys` rises together with `rst_int` without a clock. It falls on the second rising edge of `sys_clk` after `rst_int` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running slow oscillator that clocks the delay counter |
| sys_clk | input | 1 | System clock for the synchronized reset output |
| pwr_good | input | 1 | High when the supply is above the power-on threshold (asynchronous) |
| ext_rst_n | input | 1 | External reset pin level, low = hold in reset (asynchronous) |
| fast_start | input | 1 | Static option: 1 selects the short timeout, 0 the long one |
| rst_int | output | 1 | Internal reset in the oscillator domain, high = asserted |
| rst_sys | output | 1 | Internal reset released in step with `sys_clk`, high = asserted |

## Verification
The bench builds the block with SHORT_CYCLES = 8 and LONG_CYCLES = 32. With these values a short timeout takes 10 oscillator edges and a long one takes 34, so each can be counted edge by edge within a brief run, and the short and long lengths stay clearly apart. The small values also keep runs past the terminal count cheap, so a counter that wraps would show up as a new reset pulse. The oscillator and system clock periods are chosen so their edges never coincide, which keeps the two-edge release latency of `rst_sys` exact.

// File: rtl/por_delay_seq.sv
module por_delay_seq #(
  parameter int SHORT_CYCLES = 256,
  parameter int LONG_CYCLES  = 16384
) (
  input  logic osc_clk,
  input  logic sys_clk,
  input  logic pwr_good,
  input  logic ext_rst_n,
  input  logic fast_start,
  output logic rst_int,
  output logic rst_sys
);

  localparam int CW = $clog2(LONG_CYCLES);
  localparam logic [CW-1:0] LAST_SHORT = CW'(SHORT_CYCLES - 1);
  localparam logic [CW-1:0] LAST_LONG  = CW'(LONG_CYCLES - 1);

  logic          hold;
  logic [1:0]    rel_s;
  logic          sel_long;
  logic [CW-1:0] cnt;
  logic [CW-1:0] target;
  logic          done;
  logic [1:0]    sys_s;

  assign hold = ~(pwr_good & ext_rst_n);

  always_ff @(posedge osc_clk or posedge hold)
    if (hold) rel_s <= '0;
    else      rel_s <= {rel_s[0], 1'b1};

  always_ff @(posedge osc_clk)
    if (!rel_s[1]) sel_long <= ~fast_start;

  assign target = sel_long ? LAST_LONG : LAST_SHORT;

  always_ff @(posedge osc_clk or posedge hold)
    if (hold) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (rel_s[1] && !done) begin
      if (cnt == target) done <= 1'b1;
      else               cnt  <= cnt + CW'(1);
    end

  assign rst_int = ~done;

  always_ff @(posedge sys_clk or posedge rst_int)
    if (rst_int) sys_s <= 2'b11;
    else         sys_s <= {sys_s[0], 1'b0};

  assign rst_sys = sys_s[1];

  // R7
  cnt_bound_chk: assert property (@(posedge osc_clk) disable iff (hold || !rel_s[1])
    cnt <= target);

  // R7
  done_sticky_chk: assert property (@(posedge osc_clk) disable iff (hold)
    done |=> done && $stable(cnt));

  // R4
  no_early_done_chk: assert property (@(posedge osc_clk) disable iff (hold)
    !rel_s[1] |=> !done);

  // R6
  sel_frozen_chk: assert property (@(posedge osc_clk) disable iff (hold)
    rel_s[1] |=> $stable(sel_long));

  // R8
  sys_follow_chk: assert property (@(posedge sys_clk) disable iff (hold)
    rst_int |=> rst_sys);

endmodule

// File: tb/por_delay_seq_tb.sv
module por_delay_seq_tb;
  localparam int SHORT = 8;
  localparam int LONG  = 32;

  logic osc_clk, sys_clk, pwr_good, ext_rst_n, fast_start;
  logic rst_int, rst_sys;
  int n_cmp = 0;
  int n_bad = 0;

  por_delay_seq #(.SHORT_CYCLES(SHORT), .LONG_CYCLES(LONG)) u_dut (
    .osc_clk(osc_clk), .sys_clk(sys_clk), .pwr_good(pwr_good),
    .ext_rst_n(ext_rst_n), .fast_start(fast_start),
    .rst_int(rst_int), .rst_sys(rst_sys)
  );

  initial begin sys_clk = 0; forever #5 sys_clk = ~sys_clk; end
  initial begin osc_clk = 0; #3; forever #35 osc_clk = ~osc_clk; end

  // fast, order (0: pin released last, 1: power-good released last), gap, expected edges
  localparam int NV = 6;
  localparam bit VF[NV] = '{1, 0, 1, 0, 1, 0};
  localparam bit VO[NV] = '{0, 0, 1, 1, 0, 1};
  localparam int VG[NV] = '{0, 3, 5, 0, 9, 2};
  localparam int VE[NV] = '{SHORT+2, LONG+2, SHORT+2, LONG+2, SHORT+2, LONG+2};

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enter_hold(input bit f);
    @(negedge osc_clk);
    pwr_good = 0; ext_rst_n = 0; fast_start = f;
    repeat (3) @(negedge osc_clk);
  endtask

  task automatic count_to_release(output int n);
    n = 0;
    do begin
      @(posedge osc_clk); #1; n++;
    end while (rst_int && n < 300);
  endtask

  task automatic count_sys(output int n);
    n = 0;
    while (rst_sys && n < 20) begin
      @(posedge sys_clk); #1; n++;
    end
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n, m;
    pwr_good = 1; ext_rst_n = 1; fast_start = 1;
    #2 pwr_good = 0; ext_rst_n = 0;
    @(posedge sys_clk); #1;
    chk("R1 reset rst_int", rst_int, 1);
    chk("R1 reset rst_sys", rst_sys, 1);

    // power-good high but pin low for a long time: stays in reset (R1, R4)
    @(negedge osc_clk); pwr_good = 1;
    repeat (50) @(negedge osc_clk);
    chk("R1 pin low rst_int", rst_int, 1);
    chk("R1 pin low rst_sys", rst_sys, 1);

    for (int i = 0; i < NV; i++) begin
      enter_hold(VF[i]);
      if (VG[i] > 0) begin
        if (VO[i]) ext_rst_n = 1; else pwr_good = 1;
        repeat (VG[i]) @(negedge osc_clk);
        #1;
        chk("R4 one release only", rst_int, 1);
      end
      pwr_good = 1; ext_rst_n = 1;
      count_to_release(n);
      chk(VF[i] ? "R2 short timeout" : "R3 long timeout", n, VE[i]);
      count_sys(m);
      chk("R8 sys release latency", m, 2);
    end

    // R7: no wrap after terminal count
    repeat (80) @(posedge osc_clk);
    #1;
    chk("R7 stays released rst_int", rst_int, 0);
    chk("R7 stays released rst_sys", rst_sys, 0);

    // R5: drop after completion
    pwr_good = 0; #1;
    chk("R5 drop after done rst_int", rst_int, 1);
    chk("R5 drop after done rst_sys", rst_sys, 1);

    // R5: abort mid-count and restart
    enter_hold(1);
    pwr_good = 1; ext_rst_n = 1;
    repeat (5) @(posedge osc_clk);
    #1 ext_rst_n = 0; #1;
    chk("R5 abort rst_int", rst_int, 1);
    chk("R5 abort rst_sys", rst_sys, 1);
    repeat (2) @(negedge osc_clk);
    ext_rst_n = 1;
    count_to_release(n);
    chk("R5 restart full count", n, SHORT + 2);

    // R6: option changes during count are ignored
    enter_hold(0);
    pwr_good = 1; ext_rst_n = 1;
    repeat (5) @(posedge osc_clk);
    #1 fast_start = 1;
    count_to_release(m);
    chk("R6 long kept", m + 5, LONG + 2);

    enter_hold(1);
    pwr_good = 1; ext_rst_n = 1;
    repeat (4) @(posedge osc_clk);
    #1 fast_start = 0;
    count_to_release(m);
    chk("R6 short kept", m + 4, SHORT + 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule